// File: doc/BRIEF.md
# T1/E1 Receive System-Side Formatter

This block is the last stage of one T1/E1/J1 receive channel. It takes the recovered line clock, the decoded NRZ data (single-rail and dual-rail), the raw positive and negative slicer pulses, and the channel status flags. From these it drives the system-side data rails, the receive clock pin and one multi-function status pin. The recovered clock and all line-rate inputs are sampled by a fast system clock. Every output is registered, so each output reflects the inputs and configuration present at the previous system-clock edge.

An 8-bit read/write configuration register controls the formatting:

- the interface mode;
- the output polarity;
- the receive clock edge;
- the line-code choice, which is only passed on to the upstream decoder;
- the source of the multi-function pin.

That pin carries one of eight sources, but only in single-rail NRZ mode and in dual-rail sliced mode. In the other modes it is held low. In dual-rail RZ mode a marked bit appears only while the recovered clock is high.

Top module: `rx_sysif_fmt`

## Requirements
- R1: After reset the configuration reads back 0x01, and all four pin outputs (rd_pos_o, rd_neg_o, rclk_o, rmf_o) are low.
- R2: A write stores all 8 bits. cfg_rdata shows the written value on the cycle after the write strobe. The field layout is: bits [1:0] mode, bit 2 code select, bit 3 polarity, bit 4 clock edge, bits [7:5] status-pin source.
- R3: code_ami_o equals configuration bit 2. A value of 1 selects AMI; 0 selects the zero-substitution code (B8ZS for T1/J1, HDB3 for E1).
- R4: In mode 00 (single-rail NRZ), rd_pos_o carries dec_nrz and rd_neg_o stays at its inactive level.
- R5: In mode 01 (dual-rail NRZ), rd_pos_o carries dec_pos and rd_neg_o carries dec_neg.
- R6: In mode 10 (dual-rail RZ), each rail is the decoded rail ANDed with rclk_in. A mark therefore shows only in the high half of the recovered clock period.
- R7: In mode 11 (dual-rail sliced), the rails carry slc_pos and slc_neg directly, and rclk_o is held low.
- R8: In modes 00, 01 and 10, rclk_o follows rclk_in when bit 4 is 0 (rising active edge). It is the inverse of rclk_in when bit 4 is 1 (falling active edge).
- R9: When bit 3 is 1 both rails are active-low: each rail output is inverted, and the inactive level becomes high. When bit 3 is 0 they are active-high. rclk_o and rmf_o are never inverted.
- R10: In modes 00 and 11, rmf_o shows the source selected by bits [7:5]:

  | Code | Source |
  |------|--------|
  | 000 | st_prbs |
  | 001 | st_ais |
  | 010 | slc_pos XOR slc_neg |
  | 011 | rclk_in |
  | 100 | st_exz |
  | 101 | st_bpv |
  | 110 | st_exz OR st_bpv |
  | 111 | st_los |

- R11: In modes 01 and 10, rmf_o is low whatever the source selection.
- R12: Every pin output is registered. It reflects the inputs and configuration sampled at the previous rising edge of clk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the line signals |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration read-back |
| rclk_in | input | 1 | Recovered line clock level |
| dec_nrz | input | 1 | Decoded single-rail NRZ data |
| dec_pos | input | 1 | Decoded positive rail |
| dec_neg | input | 1 | Decoded negative rail |
| slc_pos | input | 1 | Slicer positive pulse |
| slc_neg | input | 1 | Slicer negative pulse |
| st_prbs | input | 1 | Pattern-match indication |
| st_ais | input | 1 | Alarm indication signal detected |
| st_exz | input | 1 | Excess zeros detected |
| st_bpv | input | 1 | Bipolar violation detected |
| st_los | input | 1 | Loss of signal |
| code_ami_o | output | 1 | Line-code select to the decoder |
| rd_pos_o | output | 1 | Positive rail, or single-rail data |
| rd_neg_o | output | 1 | Negative rail |
| rclk_o | output | 1 | Receive clock pin |
| rmf_o | output | 1 | Multi-function status pin |

## Verification
Each mode and polarity combination is first driven with all inputs low, then all inputs high, then a walking one across every input, then a pseudo-random run.

- The constant patterns expose a wrong inactive level and a wrong inversion.
- The walking one shows which input reaches which pin. It separates the decoded, sliced and status inputs, and reveals a crossed rail or a wrong status-pin encoding.
- The pseudo-random run mixes rclk_in with the data. This separates RZ gating from plain NRZ output and tells an inverted clock apart from a straight one.

All eight source codes are repeated in the two modes where the status pin is valid and in the two where it must stay quiet.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [1:0] {
    MODE_SR_NRZ = 2'b00,
    MODE_DR_NRZ = 2'b01,
    MODE_DR_RZ  = 2'b10,
    MODE_DR_SLC = 2'b11
  } rx_mode_e;

  typedef enum logic [2:0] {
    AUX_PRBS    = 3'd0,
    AUX_AIS     = 3'd1,
    AUX_SLC_XOR = 3'd2,
    AUX_RCLK    = 3'd3,
    AUX_EXZ     = 3'd4,
    AUX_BPV     = 3'd5,
    AUX_EXZ_BPV = 3'd6,
    AUX_LOS     = 3'd7
  } aux_sel_e;

  typedef struct packed {
    aux_sel_e aux_sel;   // [7:5]
    logic     clk_fall;  // [4]
    logic     pol_low;   // [3]
    logic     code_ami;  // [2]
    rx_mode_e mode;      // [1:0]
  } rx_cfg_t;

  localparam int CFG_W = $bits(rx_cfg_t);

endpackage

// File: rtl/rxf_cfg_reg.sv
module rxf_cfg_reg
  import rxf_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_VAL = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output rx_cfg_t          cfg_q
);

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= rx_cfg_t'(RESET_VAL);
    else if (we) cfg_q <= rx_cfg_t'(wdata);
  end

  // R1: register holds its reset value right after reset
  p_cfg_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cfg_q == rx_cfg_t'(RESET_VAL)));

  // R2: a write lands in full on the next cycle
  p_cfg_write_r2: assert property (@(posedge clk) disable iff (rst)
    we |=> (cfg_q == rx_cfg_t'($past(wdata))));

endmodule

// File: rtl/rxf_rail_fmt.sv
module rxf_rail_fmt
  import rxf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  rx_mode_e mode,
  input  logic     pol_low,
  input  logic     clk_fall,
  input  logic     rclk_in,
  input  logic     dec_nrz,
  input  logic     dec_pos,
  input  logic     dec_neg,
  input  logic     slc_pos,
  input  logic     slc_neg,
  output logic     rd_pos_o,
  output logic     rd_neg_o,
  output logic     rclk_o
);

  logic pos_raw, neg_raw, clk_raw;

  always_comb begin
    pos_raw = 1'b0;
    neg_raw = 1'b0;
    clk_raw = rclk_in ^ clk_fall;
    unique case (mode)
      MODE_SR_NRZ: begin
        pos_raw = dec_nrz;
      end
      MODE_DR_NRZ: begin
        pos_raw = dec_pos;
        neg_raw = dec_neg;
      end
      MODE_DR_RZ: begin
        pos_raw = dec_pos & rclk_in;
        neg_raw = dec_neg & rclk_in;
      end
      MODE_DR_SLC: begin
        pos_raw = slc_pos;
        neg_raw = slc_neg;
        clk_raw = 1'b0;
      end
      default: begin
        pos_raw = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pos_o <= 1'b0;
      rd_neg_o <= 1'b0;
      rclk_o   <= 1'b0;
    end else begin
      rd_pos_o <= pos_raw ^ pol_low;
      rd_neg_o <= neg_raw ^ pol_low;
      rclk_o   <= clk_raw;
    end
  end

  // R4: unused rail sits at the inactive level in single-rail mode
  p_sr_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SR_NRZ) |=> (rd_neg_o == $past(pol_low)));

  // R6: no mark during the low half of the recovered clock in RZ mode
  p_rz_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DR_RZ && !rclk_in) |=>
      (rd_pos_o == $past(pol_low) && rd_neg_o == $past(pol_low)));

  // R7: receive clock pin held low in sliced mode
  p_slc_clk_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DR_SLC) |=> !rclk_o);

  // R8: clock pin follows or inverts the recovered clock in clocked modes
  p_clk_edge_r8: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_DR_SLC) |=> (rclk_o == ($past(rclk_in) ^ $past(clk_fall))));

endmodule

// File: rtl/rxf_aux_mux.sv
module rxf_aux_mux
  import rxf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  rx_mode_e mode,
  input  aux_sel_e sel,
  input  logic     rclk_in,
  input  logic     slc_pos,
  input  logic     slc_neg,
  input  logic     st_prbs,
  input  logic     st_ais,
  input  logic     st_exz,
  input  logic     st_bpv,
  input  logic     st_los,
  output logic     rmf_o
);

  logic src, pin_valid;

  always_comb begin
    unique case (sel)
      AUX_PRBS:    src = st_prbs;
      AUX_AIS:     src = st_ais;
      AUX_SLC_XOR: src = slc_pos ^ slc_neg;
      AUX_RCLK:    src = rclk_in;
      AUX_EXZ:     src = st_exz;
      AUX_BPV:     src = st_bpv;
      AUX_EXZ_BPV: src = st_exz | st_bpv;
      AUX_LOS:     src = st_los;
      default:     src = 1'b0;
    endcase
  end

  assign pin_valid = (mode == MODE_SR_NRZ) || (mode == MODE_DR_SLC);

  always_ff @(posedge clk) begin
    if (rst) rmf_o <= 1'b0;
    else     rmf_o <= pin_valid & src;
  end

  // R11: pin quiet in the dual-rail NRZ and RZ modes
  p_aux_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DR_NRZ || mode == MODE_DR_RZ) |=> !rmf_o);

  // R10: clock source reaches the pin when selected in a valid mode
  p_aux_clk_r10: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_SR_NRZ || mode == MODE_DR_SLC) && sel == AUX_RCLK)
      |=> (rmf_o == $past(rclk_in)));

endmodule

// File: rtl/rx_sysif_fmt.sv
module rx_sysif_fmt
  import rxf_pkg::*;
#(
  parameter logic [7:0] CFG_RESET = 8'h01
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       rclk_in,
  input  logic       dec_nrz,
  input  logic       dec_pos,
  input  logic       dec_neg,
  input  logic       slc_pos,
  input  logic       slc_neg,
  input  logic       st_prbs,
  input  logic       st_ais,
  input  logic       st_exz,
  input  logic       st_bpv,
  input  logic       st_los,
  output logic       code_ami_o,
  output logic       rd_pos_o,
  output logic       rd_neg_o,
  output logic       rclk_o,
  output logic       rmf_o
);

  rx_cfg_t cfg_q;

  rxf_cfg_reg #(.RESET_VAL(CFG_RESET)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg_q (cfg_q)
  );

  assign cfg_rdata  = cfg_q;
  assign code_ami_o = cfg_q.code_ami;

  rxf_rail_fmt u_rail (
    .clk      (clk),
    .rst      (rst),
    .mode     (cfg_q.mode),
    .pol_low  (cfg_q.pol_low),
    .clk_fall (cfg_q.clk_fall),
    .rclk_in  (rclk_in),
    .dec_nrz  (dec_nrz),
    .dec_pos  (dec_pos),
    .dec_neg  (dec_neg),
    .slc_pos  (slc_pos),
    .slc_neg  (slc_neg),
    .rd_pos_o (rd_pos_o),
    .rd_neg_o (rd_neg_o),
    .rclk_o   (rclk_o)
  );

  rxf_aux_mux u_aux (
    .clk     (clk),
    .rst     (rst),
    .mode    (cfg_q.mode),
    .sel     (cfg_q.aux_sel),
    .rclk_in (rclk_in),
    .slc_pos (slc_pos),
    .slc_neg (slc_neg),
    .st_prbs (st_prbs),
    .st_ais  (st_ais),
    .st_exz  (st_exz),
    .st_bpv  (st_bpv),
    .st_los  (st_los),
    .rmf_o   (rmf_o)
  );

  // R3: decoder select mirrors the stored code bit
  p_code_sel_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (code_ami_o == $past(cfg_wdata[2])));

endmodule

// File: tb/rx_sysif_fmt_bench.sv
module rx_sysif_fmt_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic [10:0] vin = '0;  // {los,bpv,exz,ais,prbs,slc_neg,slc_pos,dec_neg,dec_pos,dec_nrz,rclk}
  logic code_ami_o, rd_pos_o, rd_neg_o, rclk_o, rmf_o;
  logic [7:0] cur_cfg = 8'h01;
  logic [15:0] lfsr = 16'hACE1;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_sysif_fmt u_rx_sysif_fmt (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rclk_in(vin[0]), .dec_nrz(vin[1]), .dec_pos(vin[2]), .dec_neg(vin[3]),
    .slc_pos(vin[4]), .slc_neg(vin[5]), .st_prbs(vin[6]), .st_ais(vin[7]),
    .st_exz(vin[8]), .st_bpv(vin[9]), .st_los(vin[10]),
    .code_ami_o(code_ami_o), .rd_pos_o(rd_pos_o), .rd_neg_o(rd_neg_o),
    .rclk_o(rclk_o), .rmf_o(rmf_o)
  );

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (cfg %02h vin %03h)", tag, what, act, exp, cur_cfg, vin);
    end
  endtask

  // expected pins {rd_pos, rd_neg, rclk, rmf} from the requirements
  function automatic logic [3:0] model(input logic [7:0] c, input logic [10:0] v);
    logic p, n, k, a;
    p = 1'b0; n = 1'b0; k = v[0] ^ c[4];
    case (c[1:0])
      2'b00: p = v[1];
      2'b01: begin p = v[2]; n = v[3]; end
      2'b10: begin p = v[2] & v[0]; n = v[3] & v[0]; end
      default: begin p = v[4]; n = v[5]; k = 1'b0; end
    endcase
    case (c[7:5])
      3'd0: a = v[6];
      3'd1: a = v[7];
      3'd2: a = v[4] ^ v[5];
      3'd3: a = v[0];
      3'd4: a = v[8];
      3'd5: a = v[9];
      3'd6: a = v[8] | v[9];
      default: a = v[10];
    endcase
    if (c[1:0] == 2'b01 || c[1:0] == 2'b10) a = 1'b0;
    return {p ^ c[3], n ^ c[3], k, a};
  endfunction

  task automatic write_cfg(input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_cfg = val;
  endtask

  task automatic apply(input logic [10:0] v, input string tag_rail, input string tag_aux);
    logic [3:0] e;
    @(negedge clk);
    vin = v;
    e = model(cur_cfg, v);
    @(negedge clk);
    check(tag_rail, "rd_pos", {7'd0, rd_pos_o}, {7'd0, e[3]});
    check(tag_rail, "rd_neg", {7'd0, rd_neg_o}, {7'd0, e[2]});
    check((cur_cfg[1:0] == 2'b11) ? "R7" : "R8", "rclk", {7'd0, rclk_o}, {7'd0, e[1]});
    check(tag_aux, "rmf", {7'd0, rmf_o}, {7'd0, e[0]});
  endtask

  task automatic run_set(input logic [7:0] c, input string tag_rail, input string tag_aux);
    write_cfg(c);
    apply(11'h000, tag_rail, tag_aux);
    apply(11'h7FF, tag_rail, tag_aux);
    for (int i = 0; i < 11; i++) apply(11'h001 << i, tag_rail, tag_aux);
    for (int i = 0; i < 16; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply(lfsr[10:0], tag_rail, tag_aux);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    vin = 11'h7FF;
    repeat (3) @(negedge clk);
    check("R1", "cfg_rdata", cfg_rdata, 8'h01);
    check("R1", "pins", {4'd0, rd_pos_o, rd_neg_o, rclk_o, rmf_o}, 8'h00);
    rst = 1'b0;
    vin = '0;
    cur_cfg = 8'h01;
  endtask

  task automatic t_cfg_rw();
    write_cfg(8'hA5);
    check("R2", "cfg_rdata", cfg_rdata, 8'hA5);
    write_cfg(8'h5A);
    check("R2", "cfg_rdata", cfg_rdata, 8'h5A);
  endtask

  task automatic t_code_sel();
    write_cfg(8'h04);
    check("R3", "code_ami", {7'd0, code_ami_o}, 8'h01);
    write_cfg(8'hFB);
    check("R3", "code_ami", {7'd0, code_ami_o}, 8'h00);
  endtask

  task automatic t_single_rail();  run_set(8'h00, "R4", "R10"); endtask
  task automatic t_dual_nrz();     run_set(8'h01, "R5", "R11"); endtask
  task automatic t_dual_rz();      run_set(8'h02, "R6", "R11"); endtask
  task automatic t_sliced();       run_set(8'h03, "R7", "R10"); endtask

  task automatic t_clock_edge();
    for (int m = 0; m < 3; m++) run_set(8'h10 | 8'(m), "R8", "R8");
  endtask

  task automatic t_polarity();
    for (int m = 0; m < 4; m++) begin
      run_set(8'h08 | 8'(m), "R9", "R9");
      run_set(8'h1C | 8'(m), "R9", "R9");
    end
  endtask

  task automatic t_aux_sources();
    for (int s = 0; s < 8; s++) begin
      run_set({3'(s), 5'b00000}, "R10", "R10");
      run_set({3'(s), 5'b01011}, "R10", "R10");
    end
  endtask

  task automatic t_aux_gated();
    for (int s = 0; s < 8; s++) begin
      run_set({3'(s), 5'b00001}, "R11", "R11");
      run_set({3'(s), 5'b01010}, "R11", "R11");
    end
  endtask

  task automatic t_latency();
    write_cfg(8'h00);
    @(negedge clk); vin = 11'h002;
    @(posedge clk); #1;
    vin = 11'h000;
    @(negedge clk);
    check("R12", "rd_pos registered", {7'd0, rd_pos_o}, 8'h01);
    @(negedge clk);
    check("R12", "rd_pos next", {7'd0, rd_pos_o}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_cfg_rw();
    t_code_sel();
    t_single_rail();
    t_dual_nrz();
    t_dual_rz();
    t_sliced();
    t_clock_edge();
    t_polarity();
    t_aux_sources();
    t_aux_gated();
    t_latency();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule